// File: doc/BRIEF.md
# Translated Byte String Mover

This block is a sequential engine that copies a string of bytes from one place in a 36-bit word memory to another. Each end of the string is described by a byte pointer carrying a bit position, a byte size and a word address. It keeps a remaining-byte count for each end. The engine fetches each source byte from memory and transforms it according to the selected mode. It then inserts the byte into the destination word through a read-modify-write cycle.

Four modes are available. Left-justified copy and right-justified copy move bytes unchanged. Offset copy adds a signed displacement to every byte and checks that the result fits the destination byte size. Translated copy looks each byte up in a table of packed halfword entries. Each entry carries a replacement byte and a 3-bit action code, and the code can end the move or change the significance, nonzero and minus flags. Once the source is used up, the destination is padded with a fill byte. A single-cycle completion pulse reports skip, no-skip or invalid. The final counts, pointers and flags are held on the outputs.

Top module: `bstr_mover`

## Requirements
- R1: Byte pointer layout: position in bits 35..30, size in bits 29..24, word address in bits 17..0. A step subtracts the size from the position. If the result is negative, the address is incremented and the position becomes (36 - size) mod 64. Each pointer is stepped before it is used.
- R2: A byte is read as (word >> position) masked to size bits. A store reads the destination word, replaces only the size-bit field at that position, and writes the word back, so every other bit of the word is unchanged.
- R3: Mode 0 (left-justified) copies source bytes in order. Once the source count reaches zero, it stores the fill byte until the destination count is zero. The result is skip if the source count is zero at that point. Otherwise it is no-skip, and the remaining source count is reported.
- R4: Mode 1 (right-justified): a source longer than the destination is first advanced past its excess leading bytes, which are not stored. A shorter source makes the engine store (destination - source) fill bytes first.
- R5: Mode 2 (offset): each byte plus the sign-extended 18-bit displacement is stored. If the sum has any bit set at or above the destination byte size, the move ends with no-skip. That byte still counts as consumed, and nothing is written for it.
- R6: Mode 3 (translate): the entry for byte b is in the word at table base + (b >> 1). An even b uses bits 35..18 of that word and an odd b uses bits 17..0. The action code is in entry bits 17..15, and the replacement byte is entry bits 11..0.
- R7: The translate flags are S (source length bit 35), N (bit 34) and M (bit 33). The action codes work as follows:
  - Code 0 leaves the flags unchanged.
  - Code 1 ends the move with no-skip.
  - Code 2 clears M, and code 3 sets M.
  - Code 4 sets S and N.
  - Code 5 sets N and ends the move with no-skip.
  - Code 6 sets S and N and clears M.
  - Code 7 sets S, N and M.
- R8: In translate mode, a byte is stored (as its replacement byte) only if S is set after the lookup. Otherwise it is dropped and the destination count does not change. In the other modes the flags read back as zero.
- R9: A destination length with any of bits 35..27 set gives result invalid (2) with no memory access.
- R10: A destination count of zero ends the move at once with no memory access. The result is skip only when the source count is zero too.
- R11: `done` is a one-cycle pulse. `result` is 0 for no-skip, 1 for skip and 2 for invalid. The final counts, flags and pointers are valid from `done` onward.
- R12: Each memory access holds exactly one of `mem_rd` or `mem_wr`, with a stable address and data, until the cycle in which `mem_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load operands and begin (taken only while idle) |
| mode | input | 2 | 0 left, 1 right, 2 offset, 3 translate |
| src_len_i | input | 36 | Source flags (35..33) and count (26..0) |
| src_bp_i | input | 36 | Source byte pointer |
| dst_len_i | input | 36 | Destination count; bits 35..27 must be zero |
| dst_bp_i | input | 36 | Destination byte pointer |
| fill_i | input | 36 | Fill byte |
| disp_i | input | 18 | Signed displacement for offset mode |
| tbl_i | input | AW | Translation table base address |
| busy | output | 1 | Move in progress |
| done | output | 1 | Completion pulse |
| result | output | 2 | Completion code |
| src_len_o | output | 36 | Final source flags and count |
| src_bp_o | output | 36 | Final source pointer |
| dst_len_o | output | 36 | Final destination count |
| dst_bp_o | output | 36 | Final destination pointer |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 36 | Write data |
| mem_rdata | input | 36 | Read data, valid while `mem_ready` is high |
| mem_ready | input | 1 | Access completes in this cycle |

## Verification
Two functions can fall in the same cycle:
- The table lookup that returns a terminating code also decides the flags and consumes the source byte. The bench provokes this with code 5 and with code 1 on the last source byte, and checks that the flags are updated and the count is decremented even though nothing is stored.
- In offset mode, the fit check and the source consumption happen together. A sum that spills one bit beyond the byte size must end the move with the count already reduced and the destination word untouched.

A bench memory with irregular ready stalls makes each of these decisions coincide with a held strobe.

// File: rtl/bstr_pkg.sv
package bstr_pkg;
  localparam int WW = 36;
  localparam int BPA = 18;

  typedef logic [WW-1:0] word_t;

  typedef enum logic [1:0] {
    MD_LEFT   = 2'd0,
    MD_RIGHT  = 2'd1,
    MD_OFFSET = 2'd2,
    MD_XLAT   = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    RS_NOSKIP  = 2'd0,
    RS_SKIP    = 2'd1,
    RS_INVALID = 2'd2
  } res_e;

  typedef struct packed {
    logic s;
    logic n;
    logic m;
  } xflags_t;

  // all-ones field of sz bits, saturating at the word width
  function automatic word_t field_mask(input logic [5:0] sz);
    word_t m;
    m = '0;
    for (int i = 0; i < WW; i++)
      if (i < int'(sz)) m[i] = 1'b1;
    return m;
  endfunction

  // advance a pointer by one byte
  function automatic word_t bp_step(input word_t bp);
    word_t r;
    logic [6:0] p;
    logic [5:0] s;
    r = bp;
    s = bp[29:24];
    p = {1'b0, bp[35:30]} - {1'b0, s};
    if (p[6]) begin
      r[BPA-1:0] = bp[BPA-1:0] + 1'b1;
      r[35:30]   = 6'(7'd36 - {1'b0, s});
    end else begin
      r[35:30] = p[5:0];
    end
    return r;
  endfunction
endpackage

// File: rtl/bstr_extract.sv
module bstr_extract
  import bstr_pkg::*;
(
  input  word_t      word_i,
  input  logic [5:0] pos_i,
  input  logic [5:0] size_i,
  output word_t      byte_o
);
  assign byte_o = (word_i >> pos_i) & field_mask(size_i);
endmodule

// File: rtl/bstr_insert.sv
module bstr_insert
  import bstr_pkg::*;
(
  input  word_t      word_i,
  input  word_t      val_i,
  input  logic [5:0] pos_i,
  input  logic [5:0] size_i,
  output word_t      word_o
);
  word_t fmask;
  assign fmask  = field_mask(size_i) << pos_i;
  assign word_o = (word_i & ~fmask) | ((val_i << pos_i) & fmask);
endmodule

// File: rtl/bstr_offset.sv
module bstr_offset
  import bstr_pkg::*;
(
  input  word_t       byte_i,
  input  logic [17:0] disp_i,
  input  logic [5:0]  size_i,
  output word_t       sum_o,
  output logic        fit_o
);
  assign sum_o = byte_i + {{(WW-18){disp_i[17]}}, disp_i};
  assign fit_o = (sum_o & ~field_mask(size_i)) == '0;
endmodule

// File: rtl/bstr_xlat.sv
module bstr_xlat
  import bstr_pkg::*;
#(
  parameter int TW = 12
) (
  input  word_t         entry_w,
  input  logic          odd_i,
  input  xflags_t       flg_i,
  output xflags_t       flg_o,
  output logic          term_o,
  output logic          keep_o,
  output logic [TW-1:0] xbyte_o
);
  logic [17:0] half;
  logic [2:0]  code;

  assign half    = odd_i ? entry_w[17:0] : entry_w[35:18];
  assign code    = half[17:15];
  assign xbyte_o = half[TW-1:0];

  always_comb begin
    flg_o  = flg_i;
    term_o = 1'b0;
    case (code)
      3'd1: term_o = 1'b1;
      3'd2: flg_o.m = 1'b0;
      3'd3: flg_o.m = 1'b1;
      3'd4: begin flg_o.s = 1'b1; flg_o.n = 1'b1; end
      3'd5: begin flg_o.n = 1'b1; term_o = 1'b1; end
      3'd6: begin flg_o.s = 1'b1; flg_o.n = 1'b1; flg_o.m = 1'b0; end
      3'd7: begin flg_o.s = 1'b1; flg_o.n = 1'b1; flg_o.m = 1'b1; end
      default: ;
    endcase
  end

  assign keep_o = !term_o && flg_o.s;
endmodule

// File: rtl/bstr_mover.sv
module bstr_mover
  import bstr_pkg::*;
#(
  parameter int AW = 18,
  parameter int LW = 27,
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [35:0]   src_len_i,
  input  logic [35:0]   src_bp_i,
  input  logic [35:0]   dst_len_i,
  input  logic [35:0]   dst_bp_i,
  input  logic [35:0]   fill_i,
  input  logic [17:0]   disp_i,
  input  logic [AW-1:0] tbl_i,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result,
  output logic [35:0]   src_len_o,
  output logic [35:0]   src_bp_o,
  output logic [35:0]   dst_len_o,
  output logic [35:0]   dst_bp_o,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [35:0]   mem_wdata,
  input  logic [35:0]   mem_rdata,
  input  logic          mem_ready
);
  localparam int MZW  = WW - LW;
  localparam int MIDW = 33 - LW;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DISP, ST_SRD, ST_TRD, ST_DRD, ST_DWR
  } st_e;

  st_e             st;
  mode_e           mode_q;
  logic [LW-1:0]   src_cnt, dst_cnt, pad_cnt;
  logic [MIDW-1:0] mid_q;
  logic            adv_q, done_q;
  xflags_t         flg_q;
  word_t           sbp_q, dbp_q, fill_q, cur_q, wr_q;
  logic [17:0]     disp_q;
  logic [AW-1:0]   tbl_q;
  logic [1:0]      res_q;

  // datapath helpers
  word_t          ext_byte, ins_word, off_sum;
  logic           off_fit;
  xflags_t        x_flg;
  logic           x_term, x_keep;
  logic [TW-1:0]  x_byte;
  logic [AW-1:0]  tbl_addr;

  bstr_extract u_ext (.word_i(mem_rdata), .pos_i(sbp_q[35:30]), .size_i(sbp_q[29:24]),
                      .byte_o(ext_byte));
  bstr_insert  u_ins (.word_i(mem_rdata), .val_i(cur_q), .pos_i(dbp_q[35:30]),
                      .size_i(dbp_q[29:24]), .word_o(ins_word));
  bstr_offset  u_off (.byte_i(ext_byte), .disp_i(disp_q), .size_i(dbp_q[29:24]),
                      .sum_o(off_sum), .fit_o(off_fit));
  bstr_xlat #(.TW(TW)) u_xlt (.entry_w(mem_rdata), .odd_i(cur_q[0]), .flg_i(flg_q),
                      .flg_o(x_flg), .term_o(x_term), .keep_o(x_keep), .xbyte_o(x_byte));

  assign tbl_addr = tbl_q + AW'(cur_q >> 1);

  // named events
  logic in_mbz, ev_start, ev_src_take, ev_drop, ev_store, ev_misfit;
  assign in_mbz      = dst_len_i[WW-1:LW] != '0;
  assign ev_start    = (st == ST_IDLE) && start;
  assign ev_src_take = (st == ST_SRD) && mem_ready;
  assign ev_drop     = (st == ST_TRD) && mem_ready && !x_term && !x_keep;
  assign ev_store    = (st == ST_DWR) && mem_ready;
  assign ev_misfit   = ev_src_take && (mode_q == MD_OFFSET) && !off_fit;

  always_comb begin
    mem_rd   = (st == ST_SRD) || (st == ST_TRD) || (st == ST_DRD);
    mem_wr   = (st == ST_DWR);
    mem_addr = dbp_q[AW-1:0];
    if (st == ST_SRD) mem_addr = sbp_q[AW-1:0];
    else if (st == ST_TRD) mem_addr = tbl_addr;
  end
  assign mem_wdata = wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      mode_q  <= MD_LEFT;
      src_cnt <= '0;
      dst_cnt <= '0;
      pad_cnt <= '0;
      mid_q   <= '0;
      adv_q   <= 1'b0;
      done_q  <= 1'b0;
      flg_q   <= '0;
      sbp_q   <= '0;
      dbp_q   <= '0;
      fill_q  <= '0;
      cur_q   <= '0;
      wr_q    <= '0;
      disp_q  <= '0;
      tbl_q   <= '0;
      res_q   <= RS_NOSKIP;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          mode_q  <= mode_e'(mode);
          sbp_q   <= src_bp_i;
          dbp_q   <= dst_bp_i;
          fill_q  <= fill_i;
          disp_q  <= disp_i;
          tbl_q   <= tbl_i;
          src_cnt <= src_len_i[LW-1:0];
          dst_cnt <= dst_len_i[LW-1:0];
          pad_cnt <= '0;
          adv_q   <= 1'b0;
          if (mode_e'(mode) == MD_XLAT) begin
            flg_q <= src_len_i[35:33];
            mid_q <= src_len_i[32:LW];
          end else begin
            flg_q <= '0;
            mid_q <= '0;
          end
          if (in_mbz) begin
            done_q <= 1'b1;
            res_q  <= RS_INVALID;
          end else if (dst_len_i[LW-1:0] == '0) begin
            done_q <= 1'b1;
            res_q  <= (src_len_i[LW-1:0] == '0) ? RS_SKIP : RS_NOSKIP;
          end else begin
            st <= ST_DISP;
            if (mode_e'(mode) == MD_RIGHT) begin
              if (src_len_i[LW-1:0] > dst_len_i[LW-1:0]) adv_q <= 1'b1;
              else pad_cnt <= dst_len_i[LW-1:0] - src_len_i[LW-1:0];
            end
          end
        end
        ST_DISP: begin
          if (adv_q) begin
            if (src_cnt > dst_cnt) begin
              sbp_q   <= bp_step(sbp_q);
              src_cnt <= src_cnt - 1'b1;
            end else adv_q <= 1'b0;
          end else if (pad_cnt != '0) begin
            cur_q <= fill_q;
            dbp_q <= bp_step(dbp_q);
            st    <= ST_DRD;
          end else if (dst_cnt == '0) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
            res_q  <= (src_cnt == '0) ? RS_SKIP : RS_NOSKIP;
          end else if (src_cnt != '0) begin
            sbp_q <= bp_step(sbp_q);
            st    <= ST_SRD;
          end else begin
            cur_q <= fill_q;
            dbp_q <= bp_step(dbp_q);
            st    <= ST_DRD;
          end
        end
        ST_SRD: if (mem_ready) begin
          src_cnt <= src_cnt - 1'b1;
          mid_q   <= '0;
          if (mode_q == MD_XLAT) begin
            cur_q <= ext_byte;
            st    <= ST_TRD;
          end else if (mode_q == MD_OFFSET && !off_fit) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
            res_q  <= RS_NOSKIP;
          end else begin
            cur_q <= (mode_q == MD_OFFSET) ? off_sum : ext_byte;
            dbp_q <= bp_step(dbp_q);
            st    <= ST_DRD;
          end
        end
        ST_TRD: if (mem_ready) begin
          flg_q <= x_flg;
          if (x_term) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
            res_q  <= RS_NOSKIP;
          end else if (x_keep) begin
            cur_q <= WW'(x_byte);
            dbp_q <= bp_step(dbp_q);
            st    <= ST_DRD;
          end else st <= ST_DISP;
        end
        ST_DRD: if (mem_ready) begin
          wr_q <= ins_word;
          st   <= ST_DWR;
        end
        ST_DWR: if (mem_ready) begin
          dst_cnt <= dst_cnt - 1'b1;
          if (pad_cnt != '0) pad_cnt <= pad_cnt - 1'b1;
          st <= ST_DISP;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st != ST_IDLE);
  assign done      = done_q;
  assign result    = res_q;
  assign src_len_o = {flg_q, mid_q, src_cnt};
  assign dst_len_o = {{MZW{1'b0}}, dst_cnt};
  assign src_bp_o  = sbp_q;
  assign dst_bp_o  = dbp_q;

  // R12 one strobe at a time, held steady until accepted
  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  p_hold_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) && !mem_ready |=>
      $stable(mem_addr) && $stable(mem_wdata) && mem_rd == $past(mem_rd) && mem_wr == $past(mem_wr));
  // R11 completion is a single pulse; skip implies exhausted source
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_skip_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done && result == RS_SKIP |-> src_len_o[LW-1:0] == '0);
  // R9 malformed destination length
  p_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start && in_mbz |=> done && result == RS_INVALID && !busy);
  // R8 a dropped translated byte leaves the destination count alone
  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> st == ST_DISP && $stable(dst_cnt));
  // R3 each completed store consumes one destination byte
  p_store_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_store |=> dst_cnt == $past(dst_cnt) - 1'b1);
  // R5 misfit ends with no-skip
  p_misfit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_misfit |=> done && result == RS_NOSKIP);
endmodule

// File: tb/tb_bstr_mover.sv
module tb_bstr_mover;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = '0;
  logic [35:0] src_len_i = '0, src_bp_i = '0, dst_len_i = '0, dst_bp_i = '0, fill_i = '0;
  logic [17:0] disp_i = '0;
  logic [17:0] tbl_i = '0;
  logic        busy, done, mem_rd, mem_wr, mem_ready;
  logic [1:0]  result;
  logic [35:0] src_len_o, src_bp_o, dst_len_o, dst_bp_o, mem_wdata, mem_rdata;
  logic [17:0] mem_addr;

  always #2.5 clk = ~clk;

  bstr_mover dut (.*);

  logic [35:0] mem [0:255];
  logic [7:0]  lfsr = 8'h5A;
  int          acc_cnt = 0, hs_bad = 0, cyc = 0;
  int          n_chk = 0, n_bad = 0;
  logic        pend = 1'b0, pend_rd = 1'b0;
  logic [17:0] pend_a = '0;

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready <= (lfsr[1:0] != 2'b00);
    if (mem_wr && mem_ready) mem[mem_addr[7:0]] <= mem_wdata;
    if ((mem_rd || mem_wr) && mem_ready) acc_cnt <= acc_cnt + 1;
    if (pend && (!(mem_rd || mem_wr) || mem_rd != pend_rd || mem_addr != pend_a)) hs_bad <= hs_bad + 1;
    pend    <= (mem_rd || mem_wr) && !mem_ready;
    pend_rd <= mem_rd;
    pend_a  <= mem_addr;
  end

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] w4(input logic [8:0] a, b, c, d);
    return {a, b, c, d};
  endfunction
  function automatic logic [35:0] bp9(input int p, input int a);
    return {6'(p), 6'd9, 6'd0, 18'(a)};
  endfunction
  function automatic logic [17:0] ent(input logic [2:0] code, input logic [11:0] v);
    return {code, 3'b000, v};
  endfunction

  logic [1:0]  r_res;
  logic [35:0] r_sl, r_sb, r_dl, r_db;
  int          acc0;

  task automatic run(input logic [1:0] md, input logic [35:0] sl, sb, dl, db, input logic [17:0] dsp);
    int t;
    @(negedge clk);
    mode = md; src_len_i = sl; src_bp_i = sb; dst_len_i = dl; dst_bp_i = db;
    fill_i = 36'h0AA; disp_i = dsp; tbl_i = 18'h40;
    acc0 = acc_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    if (t >= 3000) begin n_chk++; n_bad++; $display("FAIL watchdog: actual hung expected done"); end
    r_res = result; r_sl = src_len_o; r_sb = src_bp_o; r_dl = dst_len_o; r_db = dst_bp_o;
  endtask

  task automatic t_reset();
    chk("R11 reset done", {35'd0, done}, 36'd0);
    chk("R11 reset busy", {35'd0, busy}, 36'd0);
    chk("R12 reset strobes", {34'd0, mem_rd, mem_wr}, 36'd0);
  endtask

  task automatic t_left_pad();   // R3 R1 R2: three bytes plus two fills across a word edge
    mem[8'h20] = '0; mem[8'h21] = '1;
    run(2'd0, 36'd3, bp9(36, 'h10), 36'd5, bp9(36, 'h20), '0);
    chk("R3 result", {34'd0, r_res}, 36'd1);
    chk("R3 word0", mem[8'h20], w4(9'h101, 9'h102, 9'h103, 9'h0AA));
    chk("R2 word1 rmw", mem[8'h21], w4(9'h0AA, 9'h1FF, 9'h1FF, 9'h1FF));
    chk("R1 dst ptr wrap", r_db, bp9(27, 'h21));
    chk("R1 src ptr", r_sb, bp9(9, 'h10));
    chk("R3 counts", r_sl | r_dl, 36'd0);
  endtask

  task automatic t_left_long();  // R3 source longer than destination
    mem[8'h24] = '0;
    run(2'd0, 36'd6, bp9(36, 'h10), 36'd2, bp9(36, 'h24), '0);
    chk("R3 long result", {34'd0, r_res}, 36'd0);
    chk("R3 long remain", r_sl, 36'd4);
    chk("R3 long data", mem[8'h24], w4(9'h101, 9'h102, 9'h0, 9'h0));
  endtask

  task automatic t_right();      // R4 both directions
    mem[8'h25] = '0; mem[8'h26] = '0;
    run(2'd1, 36'd4, bp9(36, 'h10), 36'd2, bp9(36, 'h25), '0);
    chk("R4 skip excess", mem[8'h25], w4(9'h103, 9'h104, 9'h0, 9'h0));
    chk("R4 excess result", {34'd0, r_res}, 36'd1);
    chk("R4 excess ptr", r_sb, bp9(0, 'h10));
    run(2'd1, 36'd2, bp9(36, 'h10), 36'd4, bp9(36, 'h26), '0);
    chk("R4 prepad", mem[8'h26], w4(9'h0AA, 9'h0AA, 9'h101, 9'h102));
    chk("R4 prepad result", {34'd0, r_res}, 36'd1);
  endtask

  task automatic t_offset();     // R5
    mem[8'h27] = '0; mem[8'h28] = '0;
    run(2'd2, 36'd2, bp9(36, 'h10), 36'd2, bp9(36, 'h27), 18'h3FFFF);
    chk("R5 negative disp", mem[8'h27], w4(9'h100, 9'h101, 9'h0, 9'h0));
    chk("R5 fit result", {34'd0, r_res}, 36'd1);
    run(2'd2, 36'd1, bp9(36, 'h10), 36'd1, bp9(36, 'h28), 18'h000FE);
    chk("R5 top-fit", mem[8'h28], w4(9'h1FF, 9'h0, 9'h0, 9'h0));
    mem[8'h28] = '0;
    run(2'd2, 36'd3, bp9(36, 'h10), 36'd2, bp9(36, 'h28), 18'h00100);
    chk("R5 misfit result", {34'd0, r_res}, 36'd0);
    chk("R5 misfit consumed", r_sl, 36'd2);
    chk("R5 misfit no store", mem[8'h28], 36'd0);
    chk("R5 misfit dst count", r_dl, 36'd2);
  endtask

  task automatic t_xlat();       // R6 R7 R8
    mem[8'h29] = '0;
    run(2'd3, 36'd4, bp9(36, 'h12), 36'd3, bp9(36, 'h29), '0);
    chk("R8 drop then store", mem[8'h29], w4(9'h022, 9'h033, 9'h044, 9'h0));
    chk("R7 flags S N", r_sl, 36'hC00000000);
    chk("R6 result", {34'd0, r_res}, 36'd1);
    mem[8'h2A] = '0;
    run(2'd3, 36'h800000003, bp9(36, 'h13), 36'd3, bp9(36, 'h2A), '0);
    chk("R7 code5 result", {34'd0, r_res}, 36'd0);
    chk("R7 code5 flags", r_sl, 36'hC00000002);
    chk("R7 code5 no store", mem[8'h2A], 36'd0);
    chk("R8 code5 dst count", r_dl, 36'd3);
    mem[8'h2B] = '0;
    run(2'd3, 36'd2, bp9(36, 'h14), 36'd2, bp9(36, 'h2B), '0);
    chk("R7 code7 code6", mem[8'h2B], w4(9'h077, 9'h066, 9'h0, 9'h0));
    chk("R7 M cleared", r_sl, 36'hC00000000);
    mem[8'h2C] = '0;
    run(2'd3, 36'd1, bp9(36, 'h15), 36'd1, bp9(36, 'h2C), '0);
    chk("R7 code1 last byte", {34'd0, r_res}, 36'd0);
    chk("R7 code1 mem", mem[8'h2C], 36'd0);
  endtask

  task automatic t_edges();      // R9 R10
    run(2'd0, 36'd3, bp9(36, 'h10), 36'h008000001, bp9(36, 'h2D), '0);
    chk("R9 invalid", {34'd0, r_res}, 36'd2);
    chk("R9 no access", 36'(acc_cnt - acc0), 36'd0);
    run(2'd0, 36'd0, bp9(36, 'h10), 36'd0, bp9(36, 'h2D), '0);
    chk("R10 both zero", {34'd0, r_res}, 36'd1);
    run(2'd1, 36'd5, bp9(36, 'h10), 36'd0, bp9(36, 'h2D), '0);
    chk("R10 src left", {34'd0, r_res}, 36'd0);
    chk("R10 no access", 36'(acc_cnt - acc0), 36'd0);
    chk("R10 ptr kept", r_sb, bp9(36, 'h10));
  endtask

  always @(posedge clk)
    if (cyc == 150000) begin
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad - 1 + 1 - 1, n_chk + 1);
      $finish;
    end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[8'h10] = w4(9'h101, 9'h102, 9'h103, 9'h104);
    mem[8'h12] = w4(9'd0, 9'd1, 9'd2, 9'd3);
    mem[8'h13] = w4(9'd4, 9'd0, 9'd0, 9'd0);
    mem[8'h14] = w4(9'd5, 9'd6, 9'd0, 9'd0);
    mem[8'h15] = w4(9'd8, 9'd0, 9'd0, 9'd0);
    mem[8'h40] = {ent(3'd0, 12'h011), ent(3'd4, 12'h022)};
    mem[8'h41] = {ent(3'd3, 12'h033), ent(3'd2, 12'h044)};
    mem[8'h42] = {ent(3'd5, 12'h055), ent(3'd7, 12'h077)};
    mem[8'h43] = {ent(3'd6, 12'h066), ent(3'd0, 12'h000)};
    mem[8'h44] = {ent(3'd1, 12'h000), ent(3'd0, 12'h000)};
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_left_pad();
    t_left_long();
    t_right();
    t_offset();
    t_xlat();
    t_edges();
    chk("R12 handshake held", 36'(hs_bad), 36'd0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule